// File: doc/BRIEF.md
# Byte Table Lookup Unit

This unit translates a 32-bit index word into a 32-bit result, one byte at a time. The word is split into four byte lanes. Each lane looks up one byte in a small table built from one to four 64-bit table words, which gives 8, 16, 24 or 32 bytes. An index that points past the end of the active table does not produce zero. Instead, that lane takes the byte at the same position of a default word supplied by the caller. This lets a chain of lookups over a larger table fill the result piece by piece.

The caller drives the index word, the default word, the table words and a table-size select. The caller then pulses the start strobe for one cycle. The four lane lookups run in parallel as combinational logic. The result is captured in a register and is flagged by a valid strobe one clock later. Between operations the register keeps its last result.

Top module: `byte_xlat_unit`

## Requirements
- R1: While reset is held and after it is released, `result_o` reads 0 and `valid_o` reads 0 until the first start pulse has been registered.
- R2: `valid_o` is high in the cycle after each clock edge at which `start_i` was sampled high, and it is low after every edge at which `start_i` was sampled low.
- R3: Each result lane k (bits 8k+7..8k, k = 0..3) depends only on index bits 8k+7..8k and default bits 8k+7..8k, together with the shared table and size select. Lanes do not affect each other.
- R4: The size select `len_sel_i` encodes the table length as (len_sel_i + 1) * 8 bytes. The value 0 gives 8 bytes, 1 gives 16, 2 gives 24 and 3 gives 32.
- R5: A lane index is in range only when it is strictly less than the table length in bytes. An index equal to the length, or larger, up to 0xFF, is out of range.
- R6: For an in-range index, index bits [7:3] pick table word w, which is `table_i[64w+63:64w]`. Index bits [2:0] pick the byte within that word, and byte 0 is the least significant byte.
- R7: For an out-of-range index, the result lane equals the byte at the same lane position of `dflt_i`.
- R8: When `start_i` is sampled low, `result_o` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a lookup of the current inputs |
| index_i | input | 32 | Four byte-lane table indices |
| dflt_i | input | 32 | Fallback bytes for out-of-range lanes |
| table_i | input | 256 | Table words; word w occupies bits 64w+63..64w |
| len_sel_i | input | 2 | Table length select, number of words minus one |
| result_o | output | 32 | Registered lookup result |
| valid_o | output | 1 | High for one cycle when a new result is present |

## Verification
A wrong range comparison shows up at once on the ports. In the cycle after start, a lane whose index equals the table length shows a table byte instead of the default byte, and a lane whose index is one below the length shows the default byte instead of the table byte. A wrong word or byte select places a neighbouring table byte in a lane, visible in the same cycle. A broken hold path changes `result_o` one edge after an idle cycle with new inputs. A wrong valid register shows a strobe that is missing, stuck, or one cycle late.

// File: rtl/byte_xlat_pkg.sv
package byte_xlat_pkg;
    localparam int XL_LANES     = 4;
    localparam int XL_LANE_W    = 8;
    localparam int XL_WORD_W    = 64;
    localparam int XL_TBL_WORDS = 4;
endpackage

// File: rtl/byte_xlat_limit.sv
module byte_xlat_limit #(
    parameter int TBL_WORDS = 4,
    parameter int WORD_W    = 64,
    parameter int LIM_W     = 9,
    localparam int LEN_W    = $clog2(TBL_WORDS),
    localparam int SHIFT    = $clog2(WORD_W / 8)
) (
    input  logic [LEN_W-1:0] len_sel_i,
    output logic [LIM_W-1:0] limit_o
);
    // length in bytes = (words) * bytes-per-word (R4)
    always_comb begin
        limit_o = (LIM_W'(len_sel_i) + LIM_W'(1)) << SHIFT;
    end
endmodule

// File: rtl/byte_xlat_lane.sv
module byte_xlat_lane #(
    parameter int LANE_W    = 8,
    parameter int WORD_W    = 64,
    parameter int TBL_WORDS = 4,
    parameter int LIM_W     = 9,
    localparam int TBL_W    = WORD_W * TBL_WORDS,
    localparam int TBL_BYTES = TBL_W / LANE_W,
    localparam int SEL_W    = $clog2(TBL_BYTES)
) (
    input  logic [LANE_W-1:0] idx_i,
    input  logic [LANE_W-1:0] dflt_i,
    input  logic [TBL_W-1:0]  table_i,
    input  logic [LIM_W-1:0]  limit_i,
    output logic [LANE_W-1:0] byte_o
);
    logic             in_range;
    logic [SEL_W-1:0] flat_sel;

    always_comb begin
        // strict compare: index equal to length is out of range (R5)
        in_range = (LIM_W'(idx_i) < limit_i);
        // word select in upper bits, byte in low three bits (R6)
        flat_sel = idx_i[SEL_W-1:0];
        if (in_range) begin
            byte_o = table_i[flat_sel*LANE_W +: LANE_W];
        end else begin
            byte_o = dflt_i;  // R7
        end
    end
endmodule

// File: rtl/byte_xlat_unit.sv
module byte_xlat_unit
    import byte_xlat_pkg::*;
#(
    parameter int LANES     = XL_LANES,
    parameter int LANE_W    = XL_LANE_W,
    parameter int WORD_W    = XL_WORD_W,
    parameter int TBL_WORDS = XL_TBL_WORDS,
    localparam int DATA_W   = LANES * LANE_W,
    localparam int TBL_W    = WORD_W * TBL_WORDS,
    localparam int LEN_W    = $clog2(TBL_WORDS),
    localparam int LIM_W    = LANE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [DATA_W-1:0] dflt_i,
    input  logic [TBL_W-1:0]  table_i,
    input  logic [LEN_W-1:0]  len_sel_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              valid;
    } xl_state_t;

    xl_state_t         st_d, st_q;
    logic [LIM_W-1:0]  limit;
    logic [DATA_W-1:0] lane_bytes;

    byte_xlat_limit #(
        .TBL_WORDS (TBL_WORDS),
        .WORD_W    (WORD_W),
        .LIM_W     (LIM_W)
    ) u_limit (
        .len_sel_i (len_sel_i),
        .limit_o   (limit)
    );

    // one independent lookup per byte lane (R3)
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        byte_xlat_lane #(
            .LANE_W    (LANE_W),
            .WORD_W    (WORD_W),
            .TBL_WORDS (TBL_WORDS),
            .LIM_W     (LIM_W)
        ) u_lane (
            .idx_i   (index_i[k*LANE_W +: LANE_W]),
            .dflt_i  (dflt_i[k*LANE_W +: LANE_W]),
            .table_i (table_i),
            .limit_i (limit),
            .byte_o  (lane_bytes[k*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_i;
        if (start_i) begin
            st_d.result = lane_bytes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign valid_o  = st_q.valid;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    a_r2_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    a_r7_ff_lane0_default: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && index_i[LANE_W-1:0] == '1)
        |=> result_o[LANE_W-1:0] == $past(dflt_i[LANE_W-1:0]));

    a_r6_zero_index_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && index_i[LANE_W-1:0] == '0)
        |=> result_o[LANE_W-1:0] == $past(table_i[LANE_W-1:0]));
endmodule

// File: tb/tb_byte_xlat_unit.sv
`timescale 1ns/1ps
module tb_byte_xlat_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  index_i = '0;
    logic [31:0]  dflt_i = '0;
    logic [255:0] table_i = '0;
    logic [1:0]   len_sel_i = '0;
    logic [31:0]  result_o;
    logic         valid_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] last_exp = '0;

    always #10 clk = ~clk;

    byte_xlat_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i),
        .dflt_i(dflt_i), .table_i(table_i), .len_sel_i(len_sel_i),
        .result_o(result_o), .valid_o(valid_o)
    );

    function automatic logic [31:0] model(input logic [31:0] idx, input logic [31:0] dft,
                                          input logic [255:0] tbl, input logic [1:0] ls);
        logic [31:0] r;
        int lim;
        lim = (int'(ls) + 1) * 8;
        for (int k = 0; k < 4; k++) begin
            int b;
            b = int'(idx[k*8 +: 8]);
            if (b < lim) r[k*8 +: 8] = tbl[b*8 +: 8];
            else         r[k*8 +: 8] = dft[k*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] idx, input logic [31:0] dft,
                          input logic [1:0] ls);
        @(negedge clk);
        index_i = idx; dflt_i = dft; len_sel_i = ls; start_i = 1'b1;
        last_exp = model(idx, dft, table_i, ls);
        @(posedge clk); #1;
        check({tag, " R2 valid"}, {31'd0, valid_o}, 32'd1);
        check(tag, result_o, last_exp);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int w = 0; w < 8; w++) table_i[w*32 +: 32] = $urandom;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset result", result_o, 32'd0);
        check("R1 reset valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 post-reset result", result_o, 32'd0);
        check("R1 post-reset valid", {31'd0, valid_o}, 32'd0);

        // R7: all 0xFF indices take default bytes
        run_op("R7 all-FF", 32'hFFFF_FFFF, 32'hA1B2_C3D4, 2'd3);
        // R4/R5: index equal to length and one below, per size select
        for (int ls = 0; ls < 4; ls++) begin
            logic [7:0] l;
            l = 8'((ls + 1) * 8);
            run_op("R5 edge len", {l, l - 8'd1, l, l - 8'd1}, 32'h1122_3344, 2'(ls));
            run_op("R4 beyond", {l + 8'd1, 8'd0, 8'd7, l}, 32'h5566_7788, 2'(ls));
        end
        // R6: walk every byte of the full table
        for (int b = 0; b < 32; b += 4)
            run_op("R6 walk", {8'(b+3), 8'(b+2), 8'(b+1), 8'(b)}, 32'hDEAD_BEEF, 2'd3);
        // R3: lanes with mixed in/out of range
        run_op("R3 mixed", {8'd31, 8'd200, 8'd3, 8'd32}, 32'hCAFE_F00D, 2'd3);

        // R8: idle cycle with changed inputs keeps result, valid low
        @(negedge clk);
        index_i = ~index_i; dflt_i = ~dflt_i; len_sel_i = ~len_sel_i;
        @(posedge clk); #1;
        check("R8 hold", result_o, last_exp);
        check("R2 valid low", {31'd0, valid_o}, 32'd0);

        for (int n = 0; n < 300; n++) begin
            logic [31:0] idx;
            for (int k = 0; k < 4; k++)
                idx[k*8 +: 8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 40);
            if (n % 50 == 0)
                for (int w = 0; w < 8; w++) table_i[w*32 +: 32] = $urandom;
            run_op("R3 R6 R7 random", idx, $urandom, 2'($urandom));
        end

        @(posedge clk); #1;
        check("R2 valid drops", {31'd0, valid_o}, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule